// File: doc/BRIEF.md
# Transmit Queue to Channel Priority Selector

This block decides which transmit queue is served next and which prioritized transmit channel its frame request goes to. Every queue has a head-valid input that says a frame is waiting. Each queue also has a stored status word that sets three things: the channel it feeds, an active flag and an enable flag. Several queues may feed one channel. Software writes a queue's status word through a single-cycle write port.

When the output register is empty, the block looks at every channel that both has an eligible queue and has its channel-ready input high. It picks the one with the highest index. Channel 7 carries commands and so wins over everything. Among the data channels, 3 ranks above 2, 2 above 1, and 1 above 0. Inside the winning channel, queues take turns in round-robin order, and the search starts just after the queue that channel last had accepted. The chosen queue and channel are held on a valid/ready output until the handshake completes. The output then goes idle for one cycle before the next grant.

Top module: `txq_chan_sel`

## Requirements
- R1: After reset `out_valid` is low, and no queue is eligible until its status word has been written, whatever `head_vld` shows.
- R2: A status word written with `cfg_we` for queue `cfg_q` takes the target channel from bits [2:0], the active flag from bit 3 and the enable flag from bit 19. All other bits are ignored.
- R3: A queue is granted only if its head-valid, active and enable flags are all set.
- R4: Among channels that have an eligible queue and a high `chan_rdy` bit, the one with the highest index is granted. Channel 7 therefore beats any data channel, and data channel 3 beats 2, 1 and 0.
- R5: A channel whose `chan_rdy` bit is low is never granted.
- R6: Within a channel, the grant goes to the first eligible queue mapped to it, searching upward from the queue last accepted on that channel and wrapping around. Before a channel's first acceptance, the search starts at queue 0.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_q` and `out_ch` stay unchanged, even when other inputs change.
- R8: The cycle after a handshake (`out_valid` and `out_ready` both high), `out_valid` is low. The round-robin position of a channel moves only on a handshake.
- R9: With `out_valid` low, a grant appears one clock edge after the inputs that produce it are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Status word write strobe |
| cfg_q | input | QW (4) | Queue whose status word is written |
| cfg_word | input | 32 | Status word: channel [2:0], active bit 3, enable bit 19 |
| head_vld | input | NQ (16) | Per-queue frame-waiting flags |
| chan_rdy | input | NCH (8) | Per-channel can-accept flags |
| out_valid | output | 1 | Grant valid |
| out_ready | input | 1 | Downstream accepts the grant |
| out_q | output | QW (4) | Granted queue index |
| out_ch | output | CW (3) | Granted channel index |

## Verification
The bench builds the block with its defaults: 16 queues and 8 channels. This covers the full priority ladder, including channels 4 to 6 and the command channel. Random status writes can pile many queues onto one channel, and they exercise the round-robin wrap from queue 15 back to queue 0. Directed cases cover the field positions in the status word, the active and enable gates, and the hold of a pending grant while the inputs are scrambled.

// File: rtl/txq_chan_sel.sv
module txq_chan_sel #(
  parameter int NQ      = 16,
  parameter int NCH     = 8,
  parameter int WORD_W  = 32,
  parameter int ACT_BIT = 3,
  parameter int EN_BIT  = 19
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NQ)-1:0]    cfg_q,
  input  logic [WORD_W-1:0]        cfg_word,
  input  logic [NQ-1:0]            head_vld,
  input  logic [NCH-1:0]           chan_rdy,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [$clog2(NQ)-1:0]    out_q,
  output logic [$clog2(NCH)-1:0]   out_ch
);
  localparam int QW = $clog2(NQ);
  localparam int CW = $clog2(NCH);

  logic [CW-1:0] q_map [NQ];
  logic [NQ-1:0] q_act, q_en;
  logic [QW-1:0] rr [NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_act <= '0;
      q_en  <= '0;
      for (int i = 0; i < NQ; i++)
        q_map[i] <= CW'((i < NCH - 1) ? i : (i % 4));
    end else if (cfg_we) begin
      q_map[cfg_q] <= cfg_word[CW-1:0];
      q_act[cfg_q] <= cfg_word[ACT_BIT];
      q_en[cfg_q]  <= cfg_word[EN_BIT];
    end
  end

  wire [NQ-1:0] elig = head_vld & q_act & q_en;

  logic [NQ-1:0] in_ch [NCH];
  always_comb
    for (int c = 0; c < NCH; c++)
      for (int q = 0; q < NQ; q++)
        in_ch[c][q] = elig[q] && (q_map[q] == CW'(c));

  logic [NCH-1:0] pick_ok;
  logic [QW-1:0]  pick_q [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_rr
    always_comb begin
      pick_ok[c] = 1'b0;
      pick_q[c]  = '0;
      for (int k = NQ; k >= 1; k--) begin
        int idx;
        idx = (int'(rr[c]) + k) % NQ;
        if (in_ch[c][idx]) begin
          pick_ok[c] = 1'b1;
          pick_q[c]  = QW'(idx);
        end
      end
    end
  end

  wire [NCH-1:0] avail = pick_ok & chan_rdy;
  logic          cand_found;
  logic [CW-1:0] cand_ch;
  logic [QW-1:0] cand_q;

  always_comb begin
    cand_found = 1'b0;
    cand_ch    = '0;
    cand_q     = '0;
    for (int c = 0; c < NCH; c++)
      if (avail[c]) begin
        cand_found = 1'b1;
        cand_ch    = CW'(c);
        cand_q     = pick_q[c];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_q     <= '0;
      out_ch    <= '0;
      for (int c = 0; c < NCH; c++) rr[c] <= QW'(NQ - 1);
    end else if (out_valid) begin
      if (out_ready) begin
        out_valid  <= 1'b0;
        rr[out_ch] <= out_q;
      end
    end else if (cand_found) begin
      out_valid <= 1'b1;
      out_q     <= cand_q;
      out_ch    <= cand_ch;
    end
  end

  logic [NQ-1:0]  elig_d;
  logic [NCH-1:0] rdy_d;
  always_ff @(posedge clk) begin
    elig_d <= elig;
    rdy_d  <= chan_rdy;
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_q) && $stable(out_ch));

  a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);

  a_r3_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> elig_d[out_q]);

  a_r5_chan_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> rdy_d[out_ch]);
endmodule

// File: tb/tb_txq_chan_sel.sv
module tb_txq_chan_sel;
  localparam int NQ = 16, NCH = 8;
  logic clk = 0, rst_n = 0, cfg_we = 0, out_ready = 0;
  logic [3:0] cfg_q = 0;
  logic [31:0] cfg_word = 0;
  logic [NQ-1:0] head_vld = 0;
  logic [NCH-1:0] chan_rdy = 0;
  logic out_valid;
  logic [3:0] out_q;
  logic [2:0] out_ch;
  int checks = 0, failures = 0, cyc = 0;

  int m_map [NQ];
  bit m_act [NQ];
  bit m_en [NQ];
  int m_rr [NCH];

  txq_chan_sel dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_q(cfg_q),
    .cfg_word(cfg_word), .head_vld(head_vld), .chan_rdy(chan_rdy),
    .out_valid(out_valid), .out_ready(out_ready), .out_q(out_q), .out_ch(out_ch));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(int q, int ch, bit act, bit en, logic [31:0] junk);
    cfg_we = 1; cfg_q = 4'(q);
    cfg_word = (junk & ~32'h0008_000F) | 32'(ch & 7) | (32'(act) << 3) | (32'(en) << 19);
    @(negedge clk);
    cfg_we = 0;
    m_map[q] = ch & 7; m_act[q] = act; m_en[q] = en;
  endtask

  task automatic predict(logic [NQ-1:0] hv, logic [NCH-1:0] rd,
                         output bit found, output int q, output int ch);
    found = 0; q = 0; ch = 0;
    for (int c = NCH - 1; c >= 0 && !found; c--)
      if (rd[c])
        for (int k = 1; k <= NQ && !found; k++) begin
          int i = (m_rr[c] + k) % NQ;
          if (hv[i] && m_act[i] && m_en[i] && m_map[i] == c) begin
            found = 1; q = i; ch = c;
          end
        end
  endtask

  task automatic round(logic [NQ-1:0] hv, logic [NCH-1:0] rd, string tag);
    bit f; int q, ch;
    predict(hv, rd, f, q, ch);
    head_vld = hv; chan_rdy = rd; out_ready = 0;
    @(negedge clk);
    chk({tag, " R9 valid"}, int'(out_valid), int'(f));
    if (f) begin
      chk({tag, " queue"}, int'(out_q), q);
      chk({tag, " channel"}, int'(out_ch), ch);
      head_vld = NQ'($urandom); chan_rdy = NCH'($urandom);
      @(negedge clk);
      chk("R7 hold valid", int'(out_valid), 1);
      chk("R7 hold queue", int'(out_q), q);
      chk("R7 hold channel", int'(out_ch), ch);
      out_ready = 1;
      @(negedge clk);
      out_ready = 0; head_vld = 0;
      chk("R8 gap after handshake", int'(out_valid), 0);
      m_rr[ch] = q;
    end else
      head_vld = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NQ; i++) begin m_map[i] = 0; m_act[i] = 0; m_en[i] = 0; end
    for (int c = 0; c < NCH; c++) m_rr[c] = NQ - 1;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    rst_n = 1;
    head_vld = '1; chan_rdy = '1;
    @(negedge clk); @(negedge clk);
    chk("R1 no grant before config", int'(out_valid), 0);
    head_vld = 0;
    @(negedge clk);

    for (int i = 0; i < NQ; i++)
      cfg(i, (i < 7) ? i : (i == 7 ? 7 : i % 4), 1, 1, 32'h0);

    round('1, '1, "R4 command first");
    round(16'h010F, '1, "R4 data ch3 top");
    round(16'h010F, 8'hF7, "R5 ch3 not ready");
    round(16'h1101, 8'h01, "R6 rr first");
    round(16'h1101, 8'h01, "R6 rr second");
    round(16'h1101, 8'h01, "R6 rr third");
    round(16'h1101, 8'h01, "R6 rr wrap");
    cfg(8, 0, 0, 1, 32'h0);
    round(16'h1100, 8'h01, "R3 inactive skipped");
    cfg(12, 0, 1, 0, 32'h0);
    round(16'h1000, 8'h01, "R3 disabled no grant");
    cfg(9, 7, 1, 1, 32'hA5A0_0F70);
    round(16'h0200, '1, "R2 field positions");
    cfg(9, 6, 0, 1, 32'hFFF7_FFF8);
    round(16'h0200, '1, "R2 active bit clear");

    for (int n = 0; n < 400; n++) begin
      if ($urandom % 4 == 0)
        cfg($urandom % NQ, $urandom % NCH, ($urandom % 4) != 0,
            ($urandom % 4) != 0, $urandom);
      round(NQ'($urandom), NCH'($urandom | $urandom), "R4 R6 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule